// File: doc/BRIEF.md
# Disk DMA Command Sequencer

This block is the device-side sequencer for multi-sector DMA data commands on a parallel disk interface. The host loads a small bank of 8-bit parameter registers, then writes a command code. For a supported code the block goes busy and moves sector data one 16-bit word per DMA acknowledge strobe. It raises its DMA request only while the media side reports that data can move. When the last word of the last sector has gone, it raises a single completion interrupt. Between sectors it raises nothing.

Three commands are decoded: a DMA read (media to host), a DMA write (host to media) and a DMA identify (one sector, media to host). The data path is a pass-through. Read data comes from the media port and appears on the host data output. Write data from the host appears on the media port, with a pop or push strobe for each accepted word. The host finishes a command by reading status, and it may also read the error register. Unsupported codes are aborted at once.

Top module: `dsq_dma_seq`

## Requirements
- R1: After reset, status (register 7, and alternate status at register 8) reads 0x40, the error register (register 1) reads 0x00, and intrq and dma_req are low.
- R2: While idle, writes to registers 2 to 6 (sector count, sector number, cylinder low, cylinder high, device/head) read back unchanged, and register 1 accepts a features write. While a command is busy, every register write is ignored.
- R3: A register-7 write of 0xC8 (read), 0xCA (write) or 0xEE (identify) while idle makes status read 0x80 (bit 7 busy set, bit 6 ready clear) from the next cycle until completion. A command write made while busy has no effect on the running transfer.
- R4: dma_req is high only while busy and media_ready is high. dma_dir is 1 for read and identify and 0 for write.
- R5: Each cycle with dma_ack and dma_req both high transfers exactly one word. On read or identify, media_rd_pop pulses and host_rdata equals media_rdata. On write, media_wr_push pulses and media_wdata equals host_wdata. dma_ack while dma_req is low moves nothing.
- R6: The sector count register decrements when a sector's last word (SECTOR_WORDS per sector) is transferred. Read and write move count × SECTOR_WORDS words, a count of 0 meaning 256 sectors, and end with the count at 0.
- R7: Identify moves exactly one sector whatever the sector count holds, and leaves the sector count unchanged.
- R8: No interrupt is raised while busy. intrq rises once, in the cycle after the final word, with status 0x40 and error 0x00.
- R9: A read of register 7 clears intrq from the next cycle on. A read of register 8 leaves intrq unchanged.
- R10: Any other command code is aborted. From the next cycle status reads 0x41 (bit 0 error), error reads 0x04 (bit 2 abort) and intrq is high. The block never goes busy and never raises dma_req. The next valid command clears both error indications.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on register 7) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| intrq | output | 1 | Completion interrupt |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge, one word per high cycle |
| dma_dir | output | 1 | 1 = device to host |
| host_wdata | input | 16 | Word from host on write |
| host_rdata | output | 16 | Word to host on read or identify |
| media_ready | input | 1 | Media side can move data now |
| media_rdata | input | 16 | Word from media |
| media_rd_pop | output | 1 | Media word consumed |
| media_wdata | output | 16 | Word to media |
| media_wr_push | output | 1 | Media word delivered |

## Verification
The bench sweeps every sector count from 1 to 5 and the 0 = 256 case, for both directions, on a four-word sector. It gates media_ready so that the request drops and comes back inside sectors. A design that mistreats count 0 would stop after zero or one sector. A design that fires the interrupt per sector would show more than one rise. One that counts words on stray acknowledges would move too much data, because the bench keeps acknowledge high even while the request is low. Identify is run with a non-unit count, which catches a design that reuses the count or decrements it. A register write and a second command are injected while busy, which catches a design that accepts them. An unknown code must interrupt at once with no request, and the two status addresses must differ in whether they clear the interrupt.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
   typedef enum logic {ST_IDLE, ST_XFER} dsq_state_e;

   localparam int unsigned REG_W        = 8;
   localparam int unsigned TF_REGS      = 6;
   localparam logic [3:0]  A_ERRFEAT    = 4'd1;
   localparam logic [3:0]  A_COUNT      = 4'd2;
   localparam logic [3:0]  A_DEVHEAD    = 4'd6;
   localparam logic [3:0]  A_CMDSTAT    = 4'd7;
   localparam logic [3:0]  A_ALTSTAT    = 4'd8;
   localparam int unsigned TF_COUNT_IDX = 1;

   localparam int unsigned ST_BSY  = 7;
   localparam int unsigned ST_RDY  = 6;
   localparam int unsigned ST_ERR  = 0;
   localparam int unsigned ER_ABRT = 2;
endpackage

// File: rtl/dsq_taskfile.sv
module dsq_taskfile
   import dsq_pkg::*;
#(
   parameter int unsigned NREGS  = TF_REGS,
   parameter int unsigned CNT_IX = TF_COUNT_IDX
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [$clog2(NREGS)-1:0]   wr_idx,
   input  logic [REG_W-1:0]           wr_data,
   input  logic                       cnt_dec,
   output logic [NREGS-1:0][REG_W-1:0] tf_q
);
   initial begin : p_param_chk
      assert (CNT_IX < NREGS) else $error("count index outside register bank");
   end

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      if (g == CNT_IX) begin : g_cnt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            tf_q[g] <= '0;
            else if (wr_en && wr_idx == g[$clog2(NREGS)-1:0]) tf_q[g] <= wr_data;
            else if (cnt_dec)                      tf_q[g] <= tf_q[g] - 1'b1;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            tf_q[g] <= '0;
            else if (wr_en && wr_idx == g[$clog2(NREGS)-1:0]) tf_q[g] <= wr_data;
         end
      end
   end

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !cnt_dec) |=> $stable(tf_q)); // R2
endmodule

// File: rtl/dsq_xfer_ctr.sv
module dsq_xfer_ctr #(
   parameter int unsigned SECTOR_WORDS = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic sec_end
);
   localparam int unsigned WW   = (SECTOR_WORDS > 2) ? $clog2(SECTOR_WORDS) : 1;
   localparam bit          POW2 = (SECTOR_WORDS & (SECTOR_WORDS - 1)) == 0;

   initial begin : p_param_chk
      assert (SECTOR_WORDS >= 2) else $error("SECTOR_WORDS must be at least 2");
   end

   logic [WW-1:0] word_q;

   if (POW2) begin : g_wrap
      assign sec_end = step && (&word_q);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     word_q <= '0;
         else if (clear) word_q <= '0;
         else if (step)  word_q <= word_q + 1'b1;
      end
   end else begin : g_cmp
      localparam logic [WW-1:0] LAST = WW'(SECTOR_WORDS - 1);
      assign sec_end = step && (word_q == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       word_q <= '0;
         else if (clear)   word_q <= '0;
         else if (sec_end) word_q <= '0;
         else if (step)    word_q <= word_q + 1'b1;
      end
      AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         step |=> (word_q <= LAST)); // R6
   end
endmodule

// File: rtl/dsq_dma_seq.sv
module dsq_dma_seq
   import dsq_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned SECTOR_WORDS = 256,
   parameter logic [7:0]  CMD_READ     = 8'hC8,
   parameter logic [7:0]  CMD_WRITE    = 8'hCA,
   parameter logic [7:0]  CMD_IDENT    = 8'hEE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [3:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              intrq,
   output logic              dma_req,
   input  logic              dma_ack,
   output logic              dma_dir,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              media_ready,
   input  logic [DATA_W-1:0] media_rdata,
   output logic              media_rd_pop,
   output logic [DATA_W-1:0] media_wdata,
   output logic              media_wr_push
);
   localparam int unsigned IW = $clog2(TF_REGS);

   initial begin : p_param_chk
      assert (CMD_READ != CMD_WRITE && CMD_READ != CMD_IDENT && CMD_WRITE != CMD_IDENT)
         else $error("command codes must be distinct");
      assert (DATA_W >= 8) else $error("DATA_W too small");
   end

   dsq_state_e state_q;
   logic busy, tf_wr, cmd_wr, cmd_ok, step, sec_end, last_sec, done;
   logic dir_q, ident_q, err_q, abrt_q, irq_q;
   logic [TF_REGS-1:0][REG_W-1:0] tf_q;
   logic [IW-1:0] tf_idx;
   logic [7:0] status;

   assign busy     = (state_q == ST_XFER);
   assign tf_idx   = IW'(reg_addr - 4'd1);
   assign tf_wr    = reg_wr && !busy && reg_addr >= A_ERRFEAT && reg_addr <= A_DEVHEAD;
   assign cmd_wr   = reg_wr && !busy && reg_addr == A_CMDSTAT;
   assign cmd_ok   = reg_wdata == CMD_READ || reg_wdata == CMD_WRITE || reg_wdata == CMD_IDENT;
   assign step     = busy && dma_req && dma_ack;
   assign last_sec = ident_q || (tf_q[TF_COUNT_IDX] == 8'd1);
   assign done     = sec_end && last_sec;

   dsq_taskfile u_tf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tf_wr),
      .wr_idx  (tf_idx),
      .wr_data (reg_wdata),
      .cnt_dec (sec_end && !ident_q),
      .tf_q    (tf_q)
   );

   dsq_xfer_ctr #(.SECTOR_WORDS(SECTOR_WORDS)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (cmd_wr),
      .step    (step),
      .sec_end (sec_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dir_q   <= 1'b1;
         ident_q <= 1'b0;
         err_q   <= 1'b0;
         abrt_q  <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         if (cmd_wr) begin
            err_q  <= !cmd_ok;
            abrt_q <= !cmd_ok;
            irq_q  <= !cmd_ok;
            if (cmd_ok) begin
               state_q <= ST_XFER;
               dir_q   <= reg_wdata != CMD_WRITE;
               ident_q <= reg_wdata == CMD_IDENT;
            end
         end else if (done) begin
            state_q <= ST_IDLE;
            irq_q   <= 1'b1;
         end else if (reg_rd && reg_addr == A_CMDSTAT) begin
            irq_q <= 1'b0;
         end
      end
   end

   always_comb begin
      status         = '0;
      status[ST_BSY] = busy;
      status[ST_RDY] = !busy;
      status[ST_ERR] = err_q && !busy;
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_ERRFEAT)                            reg_rdata[ER_ABRT] = abrt_q;
      else if (reg_addr >= A_COUNT && reg_addr <= A_DEVHEAD) reg_rdata = tf_q[tf_idx];
      else if (reg_addr == A_CMDSTAT || reg_addr == A_ALTSTAT) reg_rdata = status;
   end

   assign intrq         = irq_q;
   assign dma_req       = busy && media_ready;
   assign dma_dir       = dir_q;
   assign host_rdata    = media_rdata;
   assign media_wdata   = host_wdata;
   assign media_rd_pop  = step && dir_q;
   assign media_wr_push = step && !dir_q;

   AST_NO_MID_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !intrq); // R8
   AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (intrq && !busy && !dma_req)); // R8
   AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !cmd_ok) |=> (intrq && !busy && !dma_req && status == 8'h41)); // R10
   AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == A_CMDSTAT && !busy && !reg_wr) |=> !intrq); // R9
   AST_ALT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == A_ALTSTAT && !busy && !reg_wr) |=> $stable(intrq)); // R9
endmodule

// File: tb/dsq_dma_seq_bench.sv
module dsq_dma_seq_bench;
   localparam int unsigned SW = 4;
   localparam logic [7:0] C_RD = 8'hC8, C_WR = 8'hCA, C_ID = 8'hEE;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 0, reg_rd = 0, dma_ack = 0, media_ready = 0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic [15:0] host_wdata = '0, media_rdata = '0, host_rdata, media_wdata;
   logic intrq, dma_req, dma_dir, media_rd_pop, media_wr_push;
   int checks = 0, fails = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   dsq_dma_seq #(.SECTOR_WORDS(SW)) u_dsq_dma_seq (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .intrq(intrq), .dma_req(dma_req),
      .dma_ack(dma_ack), .dma_dir(dma_dir), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .media_ready(media_ready), .media_rdata(media_rdata), .media_rd_pop(media_rd_pop),
      .media_wdata(media_wdata), .media_wr_push(media_wr_push));

   task automatic chk(string rq, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
      end
   endtask

   task automatic wr_reg(logic [3:0] a, logic [7:0] d);
      @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 0;
   endtask

   task automatic rd_reg(logic [3:0] a, output logic [7:0] d);
      @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
      @(negedge clk); reg_rd = 0;
   endtask

   // Acknowledge stays high every cycle; only cycles with the request up may move data.
   task automatic run_xfer(bit poke, output int words, output int bad, output int midirq,
                           output logic [7:0] busy_stat);
      words = 0; bad = 0; midirq = 0; busy_stat = 0;
      for (int k = 0; k < 20000; k++) begin
         @(negedge clk);
         reg_rd = 0; reg_wr = 0;
         if (intrq) break;
         media_ready = (k % 5) != 3;
         media_rdata = 16'h1000 + 16'(k);
         host_wdata  = 16'h2000 + 16'(k);
         dma_ack = 1;
         if (k == 0) begin reg_rd = 1; reg_addr = 4'd8; end
         if (poke && k == 2) begin reg_wr = 1; reg_addr = 4'd3; reg_wdata = 8'hAA; end
         if (poke && k == 3) begin reg_wr = 1; reg_addr = 4'd7; reg_wdata = C_ID; end
         #1;
         if (k == 0) busy_stat = reg_rdata;
         if (dma_req) words++;
         if (dma_req && !media_ready) bad++;
         if (dma_dir && (media_rd_pop != dma_req || (dma_req && host_rdata != media_rdata))) bad++;
         if (!dma_dir && (media_wr_push != dma_req || (dma_req && media_wdata != host_wdata))) bad++;
         if (dma_dir ? media_wr_push : media_rd_pop) bad++;
         if (intrq) midirq++;
      end
      dma_ack = 0; media_ready = 0; reg_wr = 0; reg_rd = 0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] d, bs;
      int words, bad, mid;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      rd_reg(4'd8, d); chk("R1", d, 8'h40, "alt status");
      rd_reg(4'd1, d); chk("R1", d, 8'h00, "error");
      chk("R1", {30'd0, intrq, dma_req}, 0, "intrq/dma_req");

      // R2 parameter register readback while idle
      for (int a = 2; a <= 6; a++) begin
         wr_reg(4'(a), 8'(8'h30 + a));
         rd_reg(4'(a), d); chk("R2", d, 8'h30 + a, "param readback");
      end
      wr_reg(4'd1, 8'h03);

      // R10 unsupported command
      media_ready = 1;
      wr_reg(4'd7, 8'h55);
      chk("R10", {31'd0, intrq}, 1, "abort intrq");
      chk("R10", {31'd0, dma_req}, 0, "abort dma_req");
      rd_reg(4'd8, d); chk("R10", d, 8'h41, "abort status");
      rd_reg(4'd1, d); chk("R10", d, 8'h04, "abort error");
      media_ready = 0;

      // R6 sweep of counts and both directions (0 means 256 sectors)
      for (int dir = 0; dir < 2; dir++) begin
         for (int n = 0; n <= 5; n++) begin
            wr_reg(4'd2, 8'(n));
            wr_reg(4'd3, 8'(n + 7));
            wr_reg(4'd7, dir == 0 ? C_RD : C_WR);
            chk("R4", {31'd0, dma_dir}, dir == 0 ? 1 : 0, "direction");
            run_xfer(0, words, bad, mid, bs);
            chk("R3", bs, 8'h80, "busy status");
            chk("R6", words, (n == 0 ? 256 : n) * SW, "word total");
            chk("R5", bad, 0, "per-word handshake/data errors");
            chk("R8", mid, 0, "interrupt while busy");
            rd_reg(4'd8, d); chk("R8", d, 8'h40, "completion status");
            chk("R9", {31'd0, intrq}, 1, "intrq kept after alt read");
            rd_reg(4'd1, d); chk("R10", d, 8'h00, "error cleared by valid cmd");
            rd_reg(4'd7, d); chk("R9", {31'd0, intrq}, 0, "intrq cleared by status read");
            rd_reg(4'd2, d); chk("R6", d, 0, "count at end");
            rd_reg(4'd3, d); chk("R2", d, n + 7, "sector number kept");
         end
      end

      // R7 identify: one sector, count unchanged
      wr_reg(4'd2, 8'd3);
      wr_reg(4'd7, C_ID);
      run_xfer(0, words, bad, mid, bs);
      chk("R7", words, SW, "identify words");
      chk("R5", bad, 0, "identify data");
      rd_reg(4'd2, d); chk("R7", d, 3, "identify count");
      rd_reg(4'd7, d);

      // R2/R3 writes during busy ignored
      wr_reg(4'd2, 8'd2);
      wr_reg(4'd3, 8'h11);
      wr_reg(4'd7, C_RD);
      run_xfer(1, words, bad, mid, bs);
      chk("R3", words, 2 * SW, "second command ignored");
      rd_reg(4'd3, d); chk("R2", d, 8'h11, "busy write ignored");
      rd_reg(4'd7, d);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule